// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block supervises a small processor system from inside the same clock domain. It drives a reset output that covers power-up (the chip-level synchronous reset), a manual-reset request that has been held long enough to count as deliberate, and, through an external loop, a software hang. Software proves it is alive by toggling a kick input. When no kick edge arrives within the timeout, an active-low expired output drops. A power-fail flag from an external comparator is registered and presented as an active-low warning output.

Every duration is a parameter in clock cycles. A real system sets these values for its clock frequency. A bench can shrink them to a few dozen cycles. The expired output is intended to be wired back to the manual-reset input. A timeout then has to persist for the whole qualification window before it produces a stretched reset. That reset also clears the watchdog.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `rst_o` is high. After `rst` falls, `rst_o` stays high for exactly PULSE_CYC more clock edges and then falls.
- R2: `mr_n_i` is synchronised by two flops. When it is held low for MR_QUAL_CYC consecutive edges, `rst_o` rises on the edge that comes MR_QUAL_CYC+2 edges after the input first went low.
- R3: A low on `mr_n_i` that lasts MR_QUAL_CYC-1 edges causes no reset. A single high cycle restarts the low-time count, so two such runs separated by one high cycle also cause no reset.
- R4: Each qualified request reloads the pulse timer. `rst_o` falls exactly PULSE_CYC edges after the last request, so a request made during an active pulse extends that pulse.
- R5: `wdo_n_o` (1 = running, 0 = expired) falls exactly WD_TIMEOUT_CYC edges after the last edge on which the watchdog counter was cleared.
- R6: A rising or a falling edge on `kick_i` clears the watchdog counter. The clear takes effect 3 edges after the change: two synchroniser flops plus the edge detector.
- R7: While `rst_o` is high, the watchdog counter is held at zero. `wdo_n_o` is high one edge after `rst_o` is seen high, and no timeout can occur during a reset pulse.
- R8: `pfo_n_o` is the inverse of `pfail_i` (1 = supply below threshold), delayed by one clock edge.
- R9: With `mr_n_i` tied to `wdo_n_o`, a timeout raises `rst_o` MR_QUAL_CYC+2 edges after `wdo_n_o` falls. `wdo_n_o` returns high one edge later, and `rst_o` stays high for PULSE_CYC+3 edges.
- R10: Once expired, `wdo_n_o` stays low until a kick edge or a reset pulse clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| kick_i | input | 1 | Watchdog kick; either edge clears the counter |
| mr_n_i | input | 1 | Active-low manual-reset request, asynchronous |
| pfail_i | input | 1 | Power-fail flag from comparator, 1 = below threshold |
| rst_o | output | 1 | Active-high system reset pulse |
| wdo_n_o | output | 1 | Watchdog status, low when expired |
| pfo_n_o | output | 1 | Power-fail warning, low when supply is below threshold |

## Verification
Errors in the three counters are visible at the ports as timing errors rather than value errors:
- A pulse counter that reloads or decrements wrongly moves the falling edge of `rst_o` by one or more cycles. Each pulse is therefore measured to the exact edge.
- A qualifier that misses its restart, or that counts one too many or too few, only shows up when a low run ends exactly one cycle short. A reset that should not happen then appears MR_QUAL_CYC+2 edges after the press.
- A watchdog that is not held during reset, or that sees only one kick polarity, drops `wdo_n_o` early. The error appears within one timeout period of the missed clear.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Bits needed to hold the values 0..n inclusive.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Asynchronous inputs that share one synchroniser chain.
    typedef struct packed {
        logic mr_n;
        logic kick;
    } async_in_t;

    // Synchroniser reset value: request idle (high), kick low.
    localparam async_in_t ASYNC_IDLE = '{mr_n: 1'b1, kick: 1'b0};

    typedef enum logic {
        WD_RUNNING = 1'b0,
        WD_TRIPPED = 1'b1
    } wd_state_e;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int W = 2,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sup_mr_qual.sv
module sup_mr_qual #(
    parameter int QUAL_CYC = 140_000
) (
    input  logic clk,
    input  logic rst,
    input  logic mr_n_s_i,
    output logic req_o
);
    localparam int QW = sup_pkg::cnt_w(QUAL_CYC);
    localparam logic [QW-1:0] LAST = QW'(QUAL_CYC - 1);

    logic [QW-1:0] low_cnt;

    // Counts consecutive low cycles; any high cycle restarts it.
    always_ff @(posedge clk) begin
        if (rst || mr_n_s_i)      low_cnt <= '0;
        else if (low_cnt != LAST) low_cnt <= low_cnt + 1'b1;
    end

    // Request on the QUAL_CYC-th low cycle and every later low cycle.
    assign req_o = !mr_n_s_i && (low_cnt == LAST);
endmodule

// File: rtl/sup_pulse.sv
module sup_pulse #(
    parameter int PULSE_CYC = 200_000
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic active_o
);
    localparam int PW = sup_pkg::cnt_w(PULSE_CYC);
    localparam logic [PW-1:0] FULL = PW'(PULSE_CYC);

    logic [PW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || req_i)        remain <= FULL;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign active_o = (remain != '0);
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int TIMEOUT_CYC = 1_600_000
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  logic kick_s_i,
    output logic wdo_n_o
);
    import sup_pkg::*;

    localparam int TW = cnt_w(TIMEOUT_CYC);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC);
    localparam logic [TW-1:0] PRE   = TW'(TIMEOUT_CYC - 1);

    logic      kick_q;
    logic      kick_edge;
    logic [TW-1:0] elapsed;
    wd_state_e state;

    assign kick_edge = kick_s_i ^ kick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kick_q  <= 1'b0;
            elapsed <= '0;
            state   <= WD_RUNNING;
        end else begin
            kick_q <= kick_s_i;
            if (hold_i || kick_edge) begin
                elapsed <= '0;
                state   <= WD_RUNNING;
            end else if (elapsed != LIMIT) begin
                elapsed <= elapsed + 1'b1;
                if (elapsed == PRE) state <= WD_TRIPPED;
            end
        end
    end

    assign wdo_n_o = (state != WD_TRIPPED);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int PULSE_CYC      = 200_000,
    parameter int MR_QUAL_CYC    = 140_000,
    parameter int WD_TIMEOUT_CYC = 1_600_000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    input  logic mr_n_i,
    input  logic pfail_i,
    output logic rst_o,
    output logic wdo_n_o,
    output logic pfo_n_o
);
    import sup_pkg::*;

    async_in_t raw_in;
    async_in_t sync_in;
    logic      mr_req;
    logic      pulse_active;
    logic      pfail_q;

    assign raw_in = '{mr_n: mr_n_i, kick: kick_i};

    sup_sync #(
        .W      ($bits(async_in_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL(ASYNC_IDLE)
    ) i_sync (
        .clk(clk),
        .rst(rst),
        .d_i(raw_in),
        .q_o(sync_in)
    );

    sup_mr_qual #(.QUAL_CYC(MR_QUAL_CYC)) i_mr_qual (
        .clk     (clk),
        .rst     (rst),
        .mr_n_s_i(sync_in.mr_n),
        .req_o   (mr_req)
    );

    sup_pulse #(.PULSE_CYC(PULSE_CYC)) i_pulse (
        .clk     (clk),
        .rst     (rst),
        .req_i   (mr_req),
        .active_o(pulse_active)
    );

    sup_wdog #(.TIMEOUT_CYC(WD_TIMEOUT_CYC)) i_wdog (
        .clk     (clk),
        .rst     (rst),
        .hold_i  (pulse_active),
        .kick_s_i(sync_in.kick),
        .wdo_n_o (wdo_n_o)
    );

    always_ff @(posedge clk) begin
        if (rst) pfail_q <= 1'b0;
        else     pfail_q <= pfail_i;
    end

    assign rst_o   = pulse_active;
    assign pfo_n_o = !pfail_q;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
    parameter int PULSE_CYC      = 200_000,
    parameter int WD_TIMEOUT_CYC = 1_600_000
) (
    input logic clk,
    input logic rst,
    input logic pfail_i,
    input logic rst_o,
    input logic wdo_n_o,
    input logic pfo_n_o
);
    localparam int HW = sup_pkg::cnt_w(PULSE_CYC);
    localparam int LW = sup_pkg::cnt_w(WD_TIMEOUT_CYC);
    localparam logic [HW-1:0] HMAX = HW'(PULSE_CYC);
    localparam logic [LW-1:0] LMAX = LW'(WD_TIMEOUT_CYC);

    logic [HW-1:0] high_run;
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || !rst_o)       high_run <= '0;
        else if (high_run != HMAX) high_run <= high_run + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || rst_o)        low_run <= '0;
        else if (low_run != LMAX) low_run <= low_run + 1'b1;
    end

    assert_wdo_cleared_in_reset_R7: assert property (
        @(posedge clk) disable iff (rst) rst_o |=> wdo_n_o);

    assert_pfo_low_on_fail_R8: assert property (
        @(posedge clk) disable iff (rst) pfail_i |=> !pfo_n_o);

    assert_pfo_high_on_good_R8: assert property (
        @(posedge clk) disable iff (rst) !pfail_i |=> pfo_n_o);

    assert_pulse_full_width_R4: assert property (
        @(posedge clk) disable iff (rst) $fell(rst_o) |-> (high_run >= HMAX));

    assert_no_early_timeout_R5: assert property (
        @(posedge clk) disable iff (rst) $fell(wdo_n_o) |-> (low_run >= LMAX));
endmodule

bind rst_supervisor sup_checker #(
    .PULSE_CYC     (PULSE_CYC),
    .WD_TIMEOUT_CYC(WD_TIMEOUT_CYC)
) i_sup_checker (
    .clk    (clk),
    .rst    (rst),
    .pfail_i(pfail_i),
    .rst_o  (rst_o),
    .wdo_n_o(wdo_n_o),
    .pfo_n_o(pfo_n_o)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int P = 40;   // pulse width
    localparam int Q = 12;   // manual-reset qualification
    localparam int T = 30;   // watchdog timeout

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic kick = 1'b0;
    logic mr_man = 1'b1;
    logic loop_en = 1'b0;
    logic pfail = 1'b0;
    logic mr_n;
    logic rst_o, wdo_n, pfo_n;

    int n_chk = 0;
    int n_err = 0;

    assign mr_n = loop_en ? wdo_n : mr_man;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rst_supervisor #(
        .PULSE_CYC     (P),
        .MR_QUAL_CYC   (Q),
        .WD_TIMEOUT_CYC(T),
        .SYNC_STAGES   (2)
    ) i_rst_supervisor (
        .clk    (clk),
        .rst    (rst),
        .kick_i (kick),
        .mr_n_i (mr_n),
        .pfail_i(pfail),
        .rst_o  (rst_o),
        .wdo_n_o(wdo_n),
        .pfo_n_o(pfo_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic t_powerup;
        rst = 1'b1;
        tick(3);
        check("R1", "rst_o during rst", rst_o, 1'b1);
        check("R7", "wdo_n during rst", wdo_n, 1'b1);
        check("R8", "pfo_n during rst", pfo_n, 1'b1);
        rst = 1'b0;
        tick(P - 1);
        check("R1", "rst_o last pulse cycle", rst_o, 1'b1);
        check("R7", "wdo_n held in pulse", wdo_n, 1'b1);
        tick(1);
        check("R1", "rst_o after pulse", rst_o, 1'b0);
        tick(T - 1);
        check("R5", "wdo_n one before timeout", wdo_n, 1'b1);
        tick(1);
        check("R5", "wdo_n at timeout", wdo_n, 1'b0);
        tick(5);
        check("R10", "wdo_n stays expired", wdo_n, 1'b0);
        check("R10", "no reset from timeout alone", rst_o, 1'b0);
    endtask

    task automatic t_kick;
        kick = 1'b1;
        tick(2);
        check("R6", "wdo_n before kick lands", wdo_n, 1'b0);
        tick(1);
        check("R6", "rising kick clears", wdo_n, 1'b1);
        for (int i = 0; i < 5; i++) begin
            tick(T - 5);
            kick = ~kick;
            check("R6", "alternating kicks keep alive", wdo_n, 1'b1);
        end
        // last toggle above was a falling edge
        tick(T + 2);
        check("R6", "falling kick cleared counter", wdo_n, 1'b1);
        tick(1);
        check("R5", "timeout after falling kick", wdo_n, 1'b0);
    endtask

    task automatic t_mr_short;
        logic seen;
        seen = 1'b0;
        mr_man = 1'b0;
        for (int i = 0; i < Q - 1; i++) begin tick(1); seen |= rst_o; end
        mr_man = 1'b1;
        tick(1); seen |= rst_o;
        mr_man = 1'b0;
        for (int i = 0; i < Q - 1; i++) begin tick(1); seen |= rst_o; end
        mr_man = 1'b1;
        for (int i = 0; i < Q + P; i++) begin tick(1); seen |= rst_o; end
        check("R3", "short presses give no reset", seen, 1'b0);
    endtask

    task automatic t_mr_qualify;
        check("R7", "wdo_n expired before press", wdo_n, 1'b0);
        mr_man = 1'b0;
        tick(Q);
        mr_man = 1'b1;
        tick(1);
        check("R2", "rst_o one before qualify", rst_o, 1'b0);
        tick(1);
        check("R2", "rst_o at qualify", rst_o, 1'b1);
        tick(1);
        check("R7", "reset re-arms watchdog", wdo_n, 1'b1);
        tick(P - 2);
        check("R4", "rst_o last pulse cycle", rst_o, 1'b1);
        tick(1);
        check("R4", "rst_o after full pulse", rst_o, 1'b0);
    endtask

    task automatic t_retrigger;
        kick = ~kick;
        tick(5);
        mr_man = 1'b0;
        tick(Q);
        mr_man = 1'b1;
        tick(12);
        mr_man = 1'b0;
        tick(Q);
        mr_man = 1'b1;
        tick(P - Q - 10);
        check("R4", "first pulse end extended", rst_o, 1'b1);
        tick(Q + 11);
        check("R4", "retriggered last cycle", rst_o, 1'b1);
        tick(1);
        check("R4", "retriggered pulse ends", rst_o, 1'b0);
    endtask

    task automatic t_pfail;
        pfail = 1'b1;
        check("R8", "pfo_n before edge", pfo_n, 1'b1);
        tick(1);
        check("R8", "pfo_n low on fail", pfo_n, 1'b0);
        pfail = 1'b0;
        tick(1);
        check("R8", "pfo_n high on recovery", pfo_n, 1'b1);
    endtask

    task automatic t_loop;
        int waited;
        loop_en = 1'b1;
        kick = 1'b0;
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        waited = 0;
        while (wdo_n && waited < P + T + 10) begin
            tick(1);
            waited++;
        end
        n_chk++;
        if (waited != P + T) begin
            n_err++;
            $display("FAIL R5 loop timeout cycle: actual=%0d expected=%0d", waited, P + T);
        end
        tick(Q + 1);
        check("R9", "rst_o before loop qualify", rst_o, 1'b0);
        tick(1);
        check("R9", "rst_o from loop", rst_o, 1'b1);
        check("R9", "wdo_n still low at rise", wdo_n, 1'b0);
        tick(1);
        check("R9", "wdo_n returns high", wdo_n, 1'b1);
        tick(P + 1);
        check("R9", "stretched pulse last cycle", rst_o, 1'b1);
        tick(1);
        check("R9", "stretched pulse ends", rst_o, 1'b0);
        loop_en = 1'b0;
    endtask

    initial begin
        #1;
        t_powerup();
        t_kick();
        t_mr_short();
        t_mr_qualify();
        t_retrigger();
        t_pfail();
        t_loop();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired before R1..R10 scenarios completed: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule